// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is an eight-pin general-purpose I/O port that software controls through a small register bus. Each pin has its own output value, direction and function-select bits. A pin can be a plain input, a plain output, or it can be handed to an alternate peripheral. In that last case the peripheral supplies both the driven value and the output enable for that pin. Pins reach the pad through separate input, output-value and output-enable signals.

Every pin input passes through a two-flop synchronizer. The synchronized level is visible to software. An edge detector compares the synchronized value with its value one cycle earlier. Each pin chooses whether a rising or a falling transition sets its sticky pending flag. A static level never sets a flag. Software clears a flag by writing 0 to that bit. A single interrupt request is raised while any pending flag has its mask bit set.

Register addresses on the 3-bit bus are as follows:
- 0: synchronized pin level (read only)
- 1: output value
- 2: direction
- 3: function select
- 4: edge polarity
- 5: pending flags
- 6: interrupt mask
- 7: reads as zero

Writes take effect on the rising clock edge while `wrEn` is high. Reads are combinational from `addr`.

Top module: `edge_gpio_port`

## Requirements
- R1: After reset every register reads 0. `padOe` is 0, `irq` is 0 and no flag is pending.
- R2: Address 0 returns the pin levels two clock edges after the pins change. A write to address 0 changes nothing.
- R3: With function select 0, `padOe` follows the direction bit (1 means output) and `padOut` follows the output-value bit.
- R4: With function select 1, that pin's `padOut` and `padOe` come from `altOut` and `altOe`.
- R5: With edge bit 0, a low-to-high pin transition sets the flag at address 5. The flag becomes visible three rising edges after the pin changes, and not after two.
- R6: With edge bit 1, only a high-to-low transition sets the flag. A rising transition on that pin leaves the flag at 0.
- R7: A pin held at a constant level never sets its flag, however long it is held.
- R8: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R9: If an edge is detected in the same cycle as a write of 0 to that flag bit, the flag ends up set.
- R10: `irq` is high exactly when some bit is set in both the flags and the mask. A masked flag still latches.
- R11: Addresses 1, 2, 3, 4 and 6 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| padIn | input | 8 | Pin levels from the pads |
| altOut | input | 8 | Alternate peripheral output values |
| altOe | input | 8 | Alternate peripheral output enables |
| padOut | output | 8 | Value driven toward each pad |
| padOe | output | 8 | Output enable toward each pad |
| irq | output | 1 | Combined interrupt request |

## Verification
The output path is tried with four mixes of direction, output value and function select, including split nibbles. These separate a pin driven by its own registers from one handed to the peripheral, and an enabled pin from a released one.

The interrupt path is tried with several pin patterns:
- rising edges on several pins at once
- falling edges while rising polarity is selected
- a rise on a pin set to falling polarity
- a long constant level
- an edge that lands in the same cycle as a clear

These patterns distinguish transition detection from level detection, polarity handling, and the priority of set over clear. Sampling the flag at two and three edges after a pin change pins down the synchronizer latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    REG_LEVEL = 3'd0,
    REG_OUTV  = 3'd1,
    REG_DIR   = 3'd2,
    REG_FUNC  = 3'd3,
    REG_EDGE  = 3'd4,
    REG_FLAG  = 3'd5,
    REG_MASK  = 3'd6,
    REG_NONE  = 3'd7
  } gpioReg_e;

  typedef struct packed {
    logic     wrOutv;
    logic     wrDir;
    logic     wrFunc;
    logic     wrEdge;
    logic     wrFlag;
    logic     wrMask;
    gpioReg_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strobes
);
  gpioReg_e regSel;

  always_comb begin
    regSel = gpioReg_e'(addr[2:0]);
    strobes = '0;
    strobes.rdSel = regSel;
    if (wrEn) begin
      unique case (regSel)
        REG_OUTV: strobes.wrOutv = 1'b1;
        REG_DIR:  strobes.wrDir  = 1'b1;
        REG_FUNC: strobes.wrFunc = 1'b1;
        REG_EDGE: strobes.wrEdge = 1'b1;
        REG_FLAG: strobes.wrFlag = 1'b1;
        REG_MASK: strobes.wrMask = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] altOut,
  input  logic [WIDTH-1:0] altOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic             irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] outvQ, dirQ, funcQ, edgeQ, flagQ, maskQ;
  logic [WIDTH-1:0] syncPipe [SYNC_STAGES];
  logic [WIDTH-1:0] syncQ, prevQ;
  logic [WIDTH-1:0] riseHit, fallHit, edgeHit;

  // Input synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= '0;
        else if (s == 0) syncPipe[s] <= padIn;
        else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncQ = syncPipe[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else prevQ <= syncQ;
  end

  // Per-pin edge detection with polarity select
  assign riseHit = syncQ & ~prevQ;
  assign fallHit = ~syncQ & prevQ;
  assign edgeHit = (edgeQ & fallHit) | (~edgeQ & riseHit);

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outvQ <= '0;
      dirQ  <= '0;
      funcQ <= '0;
      edgeQ <= '0;
      maskQ <= '0;
    end else begin
      if (strobes.wrOutv) outvQ <= wrData;
      if (strobes.wrDir)  dirQ  <= wrData;
      if (strobes.wrFunc) funcQ <= wrData;
      if (strobes.wrEdge) edgeQ <= wrData;
      if (strobes.wrMask) maskQ <= wrData;
    end
  end

  // Sticky flags: a written 0 clears, a new edge wins over the clear
  logic [WIDTH-1:0] flagKeep;
  assign flagKeep = strobes.wrFlag ? (flagQ & wrData) : flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else flagQ <= flagKeep | edgeHit;
  end

  // Pin multiplexer
  genvar p;
  generate
    for (p = 0; p < WIDTH; p++) begin : g_pin
      assign padOut[p] = funcQ[p] ? altOut[p] : outvQ[p];
      assign padOe[p]  = funcQ[p] ? altOe[p]  : dirQ[p];
    end
  endgenerate

  assign irq = |(flagQ & maskQ);

  always_comb begin
    unique case (strobes.rdSel)
      REG_LEVEL: rdData = syncQ;
      REG_OUTV:  rdData = outvQ;
      REG_DIR:   rdData = dirQ;
      REG_FUNC:  rdData = funcQ;
      REG_EDGE:  rdData = edgeQ;
      REG_FLAG:  rdData = flagQ;
      REG_MASK:  rdData = maskQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/edge_gpio_port.sv
module edge_gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  padIn,
  input  logic [WIDTH-1:0]  altOut,
  input  logic [WIDTH-1:0]  altOe,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic              irq
);
  ctrlStrobes_t strobes;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .strobes (strobes)
  );

  gpio_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .rdData  (rdData),
    .padIn   (padIn),
    .altOut  (altOut),
    .altOe   (altOe),
    .padOut  (padOut),
    .padOe   (padOe),
    .irq     (irq)
  );
endmodule

// File: rtl/edge_gpio_port_chk.sv
module edge_gpio_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  padOe,
  input logic              irq,
  input logic [WIDTH-1:0]  flagQ,
  input logic [WIDTH-1:0]  maskQ,
  input logic [WIDTH-1:0]  syncQ,
  input logic [WIDTH-1:0]  prevQ,
  input logic [WIDTH-1:0]  edgeHit
);
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (padOe == '0 && irq == 1'b0 && flagQ == '0);
    end
  end

  // R7: a newly set flag needs a level change seen one cycle before
  assert_no_static_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(flagQ & ~$past(flagQ))) |-> ($past(syncQ) != $past(prevQ)));

  // R5 and R9: a detected edge always leaves its flag set
  assert_edge_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeHit) |=> ((flagQ & $past(edgeHit)) == $past(edgeHit)));

  // R8: a flag only drops after a write to the flag address
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flagQ) & ~flagQ)) |-> $past(wrEn && addr == 3'd5));

  // R10: a request needs an unmasked pending flag
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((flagQ & maskQ) != '0));
endmodule

bind edge_gpio_port edge_gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .padOe   (padOe),
  .irq     (irq),
  .flagQ   (u_dp.flagQ),
  .maskQ   (u_dp.maskQ),
  .syncQ   (u_dp.syncQ),
  .prevQ   (u_dp.prevQ),
  .edgeHit (u_dp.edgeHit)
);

// File: tb/edge_gpio_port_bench.sv
module edge_gpio_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] padIn = 8'h00;
  logic [7:0] altOut = 8'h00;
  logic [7:0] altOe = 8'h00;
  logic [7:0] padOut, padOe;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_gpio_port u_edge_gpio_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .altOut(altOut), .altOe(altOe),
    .padOut(padOut), .padOe(padOe), .irq(irq)
  );

  // Each entry: dir, outv, func, altOut, altOe, expected padOut, expected padOe
  localparam logic [55:0] VECS [4] = '{
    {8'hFF, 8'hA5, 8'h00, 8'h3C, 8'h0F, 8'hA5, 8'hFF},
    {8'h0F, 8'hFF, 8'hF0, 8'h5A, 8'hC3, 8'h5F, 8'hCF},
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00},
    {8'hF0, 8'h0F, 8'hFF, 8'h81, 8'h18, 8'h81, 8'h18}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic setPad(input logic [7:0] v);
    @(negedge clk);
    padIn = v;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    logic [7:0] v;
    tick(3);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check("R1 reset read", v, 8'h00);
    end
    check("R1 padOe", padOe, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R3 R4 R11 output table
    for (int i = 0; i < 4; i++) begin
      wr(3'd2, VECS[i][55:48]);
      wr(3'd1, VECS[i][47:40]);
      wr(3'd3, VECS[i][39:32]);
      @(negedge clk);
      altOut = VECS[i][31:24];
      altOe = VECS[i][23:16];
      #1;
      check("R3/R4 padOut", padOut, VECS[i][15:8]);
      check("R3/R4 padOe", padOe, VECS[i][7:0]);
      rd(3'd2, v); check("R11 dir readback", v, VECS[i][55:48]);
      rd(3'd3, v); check("R11 func readback", v, VECS[i][39:32]);
      rd(3'd1, v); check("R11 outv readback", v, VECS[i][47:40]);
    end
    wr(3'd3, 8'h00); wr(3'd2, 8'h00);

    // R2 level latency and read-only
    setPad(8'h96);
    tick(1);
    rd(3'd0, v); check("R2 level before sync", v, 8'h00);
    setPad(8'h96);
    tick(3);
    rd(3'd0, v); check("R2 level", v, 8'h96);
    wr(3'd0, 8'hFF);
    rd(3'd0, v); check("R2 write ignored", v, 8'h96);
    rd(3'd5, v); check("R5 multi rise flags", v, 8'h96);
    wr(3'd5, 8'h00);
    rd(3'd5, v); check("R8 clear all", v, 8'h00);
    setPad(8'h00);
    tick(5);
    rd(3'd5, v); check("R6 fall ignored on rise select", v, 8'h00);

    // R5 latency, R10 masking
    setPad(8'h01);
    tick(2);
    rd(3'd5, v); check("R5 flag not yet", v, 8'h00);
    tick(1);
    rd(3'd5, v); check("R5 flag set", v, 8'h01);
    check("R10 masked irq", {7'b0, irq}, 8'h00);
    wr(3'd6, 8'h01);
    rd(3'd6, v); check("R11 mask readback", v, 8'h01);
    check("R10 irq on", {7'b0, irq}, 8'h01);
    wr(3'd6, 8'hFE);
    check("R10 other mask", {7'b0, irq}, 8'h00);
    wr(3'd6, 8'h00);

    // R8 sticky
    wr(3'd5, 8'hFF);
    rd(3'd5, v); check("R8 write one keeps", v, 8'h01);
    wr(3'd5, 8'hFE);
    rd(3'd5, v); check("R8 write zero clears", v, 8'h00);

    // R6 falling select
    wr(3'd4, 8'h02);
    rd(3'd4, v); check("R11 edge readback", v, 8'h02);
    setPad(8'h03);
    tick(4);
    rd(3'd5, v); check("R6 rise ignored", v, 8'h00);
    setPad(8'h01);
    tick(4);
    rd(3'd5, v); check("R6 fall sets", v, 8'h02);
    wr(3'd5, 8'h00);

    // R7 constant level
    tick(200);
    rd(3'd5, v); check("R7 constant level", v, 8'h00);
    setPad(8'hFF);
    tick(4);
    wr(3'd5, 8'h00);
    tick(200);
    rd(3'd5, v); check("R7 constant high", v, 8'h00);
    setPad(8'h00);
    tick(4);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h00);

    // R9 edge beats clear in the same cycle
    setPad(8'h01);
    tick(2);
    wr(3'd5, 8'h00);
    rd(3'd5, v); check("R9 set wins over clear", v, 8'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule